// File: doc/BRIEF.md
# Paired-Page Translation Lookup Buffer

This block is a fully associative address translation buffer. Every entry maps a pair of neighbouring virtual pages, an even one and an odd one. Each page of the pair has its own frame number, valid flag and dirty flag. Each entry also carries its own page size, chosen by a mask field. A lookup presents a virtual address, the current address-space identifier and a read/write flag. All entries are compared in parallel. One clock later the block returns either a physical address tagged writable or read-only, or an exception class.

Entries are loaded through a separate write port, one entry per cycle, by index. The block reports three kinds of fault: a refill miss, an invalid page and a write to a clean page. A quiet-lookup input turns any of these faults into a plain failure with no exception report. Callers use this mode for probes that must not trap.

Top module: `tlb_pair_lookup`

## Requirements
- R1: `rsp_valid` is 1 in exactly the cycle after a cycle with `lk_valid`=1. When `rsp_valid` is 0, every other response output is 0. `rsp_ok` and `rsp_exc` are never both 1.
- R2: The mask field takes the values 0x000, 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF and 0xFFF. These select a page shift of 12, 14, 16, 18, 20, 22 and 24 bits. An entry covers two pages of 2^shift bytes each.
- R3: An entry whose mask is any other value never matches a lookup.
- R4: An entry matches when two conditions hold. First, virtual address bits [VA_W-1:shift+1] equal the same bits of {vpn2, 13'b0}, where the vpn2 field holds address bits [VA_W-1:13]. Second, either the address-space IDs are equal or the entry's global bit is 1.
- R5: Address bit [shift] selects the half. A 0 selects the even-page frame, valid and dirty; a 1 selects the odd-page set.
- R6: On success, `rsp_ok`=1. `rsp_paddr` is (frame << 12) OR (address AND (2^shift - 1)). `rsp_writable` equals the selected dirty bit.
- R7: A match whose selected valid bit is 0 reports `rsp_exc`=1 with `rsp_refill`=0. The code is 2 for a read (load) and 3 for a write (store).
- R8: A write to a valid page whose dirty bit is 0 reports `rsp_exc`=1, code 1 and `rsp_refill`=0. A read of such a page succeeds with `rsp_writable`=0.
- R9: When no entry matches, the block reports `rsp_exc`=1 and `rsp_refill`=1. The code is 2 for a read and 3 for a write.
- R10: With `lk_noexc`=1, any failure returns `rsp_ok`=0, `rsp_exc`=0, code 0 and `rsp_refill`=0.
- R11: When several entries match, the lowest-numbered entry decides the result.
- R12: An entry written in one cycle is used by a lookup in the next cycle. A lookup in the same cycle as the write sees the old contents.
- R13: Reset clears every entry field to zero. A lookup of address 0 with ID 0 then matches entry 0, which is invalid, and reports code 2 with no refill. Reset also clears all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address |
| lk_asid | input | ASID_W | Current address-space ID |
| lk_write | input | 1 | 1 = store access, 0 = load |
| lk_noexc | input | 1 | Quiet lookup: fail without exception |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | IDX_W | Entry index to load |
| wr_mask | input | 12 | Page-size mask |
| wr_vpn2 | input | VA_W-13 | Virtual page-pair number (address bits [VA_W-1:13]) |
| wr_asid | input | ASID_W | Entry address-space ID |
| wr_global | input | 1 | Entry ignores the address-space ID |
| wr_pfn0 | input | PFN_W | Even-page frame number |
| wr_v0 | input | 1 | Even-page valid |
| wr_d0 | input | 1 | Even-page dirty (writable) |
| wr_pfn1 | input | PFN_W | Odd-page frame number |
| wr_v1 | input | 1 | Odd-page valid |
| wr_d1 | input | 1 | Odd-page dirty (writable) |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_paddr | output | PFN_W+12 | Physical address |
| rsp_writable | output | 1 | Page is writable |
| rsp_exc | output | 1 | Exception reported |
| rsp_exc_code | output | 2 | 1 modify, 2 load, 3 store |
| rsp_refill | output | 1 | Exception is a refill miss |

## Verification
Directed lookups use small pages, 64 KB pages and 16 MB pages, and hit both halves of each pair. This separates the mask decode from the even/odd select and from the offset merge. Read and write pairs against clean, dirty and invalid halves separate the modify fault from the invalid fault and from success. Address-space mismatch against global and non-global entries separates a refill from a hit. Overlapping entries, an illegal mask, a quiet lookup and a lookup in the same cycle as a write cover priority, rejection, suppression and write visibility. A long stretch of random writes and lookups over a small address range is then compared, cycle by cycle, against a behavioural model.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;

  localparam int MASK_W     = 12;
  localparam int MIN_SHIFT  = 12;
  localparam int SIZE_STEPS = 7;

  localparam logic [1:0] EXC_NONE = 2'd0;
  localparam logic [1:0] EXC_MOD  = 2'd1;
  localparam logic [1:0] EXC_LOAD = 2'd2;
  localparam logic [1:0] EXC_STOR = 2'd3;

  // a legal mask is a run of ones, an even count of them, starting at bit 0
  function automatic logic mask_ok(input logic [MASK_W-1:0] m);
    logic r;
    r = 1'b0;
    for (int k = 0; k < SIZE_STEPS; k++)
      if (m == MASK_W'((1 << (2 * k)) - 1)) r = 1'b1;
    return r;
  endfunction

  function automatic logic [4:0] mask_shift(input logic [MASK_W-1:0] m);
    return 5'(MIN_SHIFT + $countones(m));
  endfunction

endpackage

// File: rtl/tlb_pair_entry.sv
module tlb_pair_entry
  import tlb_pair_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 24,
  localparam int VPN_W = VA_W - 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MASK_W-1:0] in_mask,
  input  logic [VPN_W-1:0]  in_vpn2,
  input  logic [ASID_W-1:0] in_asid,
  input  logic              in_global,
  input  logic [PFN_W-1:0]  in_pfn0,
  input  logic              in_v0,
  input  logic              in_d0,
  input  logic [PFN_W-1:0]  in_pfn1,
  input  logic              in_v1,
  input  logic              in_d1,
  input  logic [VA_W-1:0]   q_vaddr,
  input  logic [ASID_W-1:0] q_asid,
  output logic              hit,
  output logic [PFN_W-1:0]  pick_pfn,
  output logic              pick_v,
  output logic              pick_d,
  output logic [4:0]        shift
);

  logic [MASK_W-1:0] mask_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic              glob_q;
  logic [PFN_W-1:0]  pfn0_q, pfn1_q;
  logic              v0_q, d0_q, v1_q, d1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0; vpn_q <= '0; asid_q <= '0; glob_q <= 1'b0;
      pfn0_q <= '0; v0_q <= 1'b0; d0_q <= 1'b0;
      pfn1_q <= '0; v1_q <= 1'b0; d1_q <= 1'b0;
    end else if (load) begin
      mask_q <= in_mask; vpn_q <= in_vpn2; asid_q <= in_asid; glob_q <= in_global;
      pfn0_q <= in_pfn0; v0_q <= in_v0; d0_q <= in_d0;
      pfn1_q <= in_pfn1; v1_q <= in_v1; d1_q <= in_d1;
    end
  end

  logic [VA_W-1:0] keep_hi;
  logic [VA_W-1:0] diff;
  logic            odd;

  always_comb begin
    shift   = mask_shift(mask_q);
    keep_hi = {VA_W{1'b1}} << (shift + 5'd1);
    diff    = q_vaddr ^ {vpn_q, 13'b0};
    hit     = mask_ok(mask_q) && ((diff & keep_hi) == '0) &&
              (glob_q || (asid_q == q_asid));
    odd     = q_vaddr[shift];
    pick_pfn = odd ? pfn1_q : pfn0_q;
    pick_v   = odd ? v1_q : v0_q;
    pick_d   = odd ? d1_q : d0_q;
  end

endmodule

// File: rtl/tlb_pair_prio.sv
module tlb_pair_prio #(
  parameter int N     = 48,
  parameter int PFN_W = 24
) (
  input  logic [N-1:0]            hits,
  input  logic [N-1:0][PFN_W-1:0] pfns,
  input  logic [N-1:0]            vs,
  input  logic [N-1:0]            ds,
  input  logic [N-1:0][4:0]       shifts,
  output logic                    any,
  output logic [PFN_W-1:0]        pfn,
  output logic                    v,
  output logic                    d,
  output logic [4:0]              shift
);

  // walk from the top so the lowest matching index is applied last
  always_comb begin
    any   = |hits;
    pfn   = '0;
    v     = 1'b0;
    d     = 1'b0;
    shift = 5'd12;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        pfn   = pfns[i];
        v     = vs[i];
        d     = ds[i];
        shift = shifts[i];
      end
    end
  end

endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
  import tlb_pair_pkg::*;
#(
  parameter int N_ENT  = 48,
  parameter int VA_W   = 32,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 24,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int VPN_W = VA_W - 13,
  localparam int PA_W  = PFN_W + 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  input  logic              lk_noexc,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [11:0]       wr_mask,
  input  logic [VPN_W-1:0]  wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic              wr_v0,
  input  logic              wr_d0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic              wr_v1,
  input  logic              wr_d1,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_writable,
  output logic              rsp_exc,
  output logic [1:0]        rsp_exc_code,
  output logic              rsp_refill
);

  logic [N_ENT-1:0]            hit_vec;
  logic [N_ENT-1:0][PFN_W-1:0] pfn_vec;
  logic [N_ENT-1:0]            v_vec, d_vec;
  logic [N_ENT-1:0][4:0]       sh_vec;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    tlb_pair_entry #(.VA_W(VA_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .load(wr_en && (wr_idx == IDX_W'(g))),
      .in_mask(wr_mask), .in_vpn2(wr_vpn2), .in_asid(wr_asid), .in_global(wr_global),
      .in_pfn0(wr_pfn0), .in_v0(wr_v0), .in_d0(wr_d0),
      .in_pfn1(wr_pfn1), .in_v1(wr_v1), .in_d1(wr_d1),
      .q_vaddr(lk_vaddr), .q_asid(lk_asid),
      .hit(hit_vec[g]), .pick_pfn(pfn_vec[g]), .pick_v(v_vec[g]),
      .pick_d(d_vec[g]), .shift(sh_vec[g])
    );
  end

  // named internal events, observed by the bound checker
  logic             any_hit;
  logic [PFN_W-1:0] sel_pfn;
  logic             sel_v, sel_d;
  logic [4:0]       sel_shift;

  tlb_pair_prio #(.N(N_ENT), .PFN_W(PFN_W)) u_prio (
    .hits(hit_vec), .pfns(pfn_vec), .vs(v_vec), .ds(d_vec), .shifts(sh_vec),
    .any(any_hit), .pfn(sel_pfn), .v(sel_v), .d(sel_d), .shift(sel_shift)
  );

  logic            n_ok, n_exc, n_refill, n_wr;
  logic [1:0]      n_code;
  logic [PA_W-1:0] n_pa;
  logic [VA_W-1:0] off_keep;

  always_comb begin
    off_keep = ~({VA_W{1'b1}} << sel_shift);
    n_pa     = {sel_pfn, 12'b0} | PA_W'(lk_vaddr & off_keep);
    n_ok     = 1'b0;
    n_wr     = 1'b0;
    n_exc    = 1'b1;
    n_refill = 1'b0;
    n_code   = lk_write ? EXC_STOR : EXC_LOAD;
    if (!any_hit) begin
      n_refill = 1'b1;
    end else if (!sel_v) begin
      n_refill = 1'b0;
    end else if (lk_write && !sel_d) begin
      n_code = EXC_MOD;
    end else begin
      n_ok  = 1'b1;
      n_wr  = sel_d;
      n_exc = 1'b0;
      n_code = EXC_NONE;
    end
    if (n_exc && lk_noexc) begin
      n_exc    = 1'b0;
      n_code   = EXC_NONE;
      n_refill = 1'b0;
    end
    if (!n_ok) n_pa = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !lk_valid) begin
      rsp_valid    <= 1'b0;
      rsp_ok       <= 1'b0;
      rsp_paddr    <= '0;
      rsp_writable <= 1'b0;
      rsp_exc      <= 1'b0;
      rsp_exc_code <= EXC_NONE;
      rsp_refill   <= 1'b0;
    end else begin
      rsp_valid    <= 1'b1;
      rsp_ok       <= n_ok;
      rsp_paddr    <= n_pa;
      rsp_writable <= n_wr;
      rsp_exc      <= n_exc;
      rsp_exc_code <= n_code;
      rsp_refill   <= n_refill;
    end
  end

endmodule

// File: rtl/tlb_pair_chk.sv
module tlb_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_valid,
  input logic       lk_write,
  input logic       lk_noexc,
  input logic       any_hit,
  input logic       sel_v,
  input logic       sel_d,
  input logic       rsp_valid,
  input logic       rsp_ok,
  input logic       rsp_writable,
  input logic       rsp_exc,
  input logic [1:0] rsp_exc_code,
  input logic       rsp_refill
);

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_ok && !rsp_exc && !rsp_refill)); // R1
  AST_OK_EXC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ok && rsp_exc)); // R1
  AST_MISS_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !any_hit && !lk_noexc) |=> (rsp_exc && rsp_refill && rsp_exc_code[1])); // R9
  AST_INVALID_NO_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && any_hit && !sel_v && !lk_noexc) |=> (rsp_exc && !rsp_refill && rsp_exc_code[1])); // R7
  AST_MOD_ON_CLEAN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && any_hit && sel_v && !sel_d && lk_write && !lk_noexc) |=> (rsp_exc && rsp_exc_code == 2'd1)); // R8
  AST_READ_VALID_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && any_hit && sel_v && !lk_write) |=> (rsp_ok && rsp_writable == $past(sel_d))); // R6
  AST_QUIET_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_noexc) |=> (!rsp_exc && !rsp_refill)); // R10

endmodule

bind tlb_pair_lookup tlb_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
  .lk_noexc(lk_noexc), .any_hit(any_hit), .sel_v(sel_v), .sel_d(sel_d),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_writable(rsp_writable),
  .rsp_exc(rsp_exc), .rsp_exc_code(rsp_exc_code), .rsp_refill(rsp_refill)
);

// File: tb/sim_tlb_pair_lookup.sv
module sim_tlb_pair_lookup;

  localparam int N  = 48;
  localparam int VW = 32;
  localparam int AW = 8;
  localparam int FW = 24;
  localparam int IW = 6;
  localparam int PW = FW + 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          lk_valid = 0, lk_write = 0, lk_noexc = 0;
  logic [VW-1:0] lk_vaddr = '0;
  logic [AW-1:0] lk_asid = '0;
  logic          wr_en = 0, wr_global = 0, wr_v0 = 0, wr_d0 = 0, wr_v1 = 0, wr_d1 = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [11:0]   wr_mask = '0;
  logic [VW-14:0] wr_vpn2 = '0;
  logic [AW-1:0] wr_asid = '0;
  logic [FW-1:0] wr_pfn0 = '0, wr_pfn1 = '0;
  logic          rsp_valid, rsp_ok, rsp_writable, rsp_exc, rsp_refill;
  logic [PW-1:0] rsp_paddr;
  logic [1:0]    rsp_exc_code;

  tlb_pair_lookup u0 (.*);

  // behavioural model state
  logic [11:0]    m_mask [N];
  logic [VW-14:0] m_vpn  [N];
  logic [AW-1:0]  m_asid [N];
  logic           m_g [N], m_v0 [N], m_d0 [N], m_v1 [N], m_d1 [N];
  logic [FW-1:0]  m_p0 [N], m_p1 [N];

  typedef struct packed {
    logic valid; logic ok; logic [PW-1:0] pa; logic wr;
    logic exc; logic [1:0] code; logic refill;
  } rsp_t;

  int checks = 0, errors = 0;

  function automatic int page_bits(input logic [11:0] m);
    int b = -1;
    case (m)
      12'h000: b = 12; 12'h003: b = 14; 12'h00F: b = 16; 12'h03F: b = 18;
      12'h0FF: b = 20; 12'h3FF: b = 22; 12'hFFF: b = 24;
      default: b = -1;
    endcase
    return b;
  endfunction

  function automatic rsp_t model(input logic lv, input logic [VW-1:0] va,
                                 input logic [AW-1:0] as, input logic w, input logic nx);
    rsp_t r;
    int who = -1;
    int pb = 12;
    logic odd, v, d;
    logic [FW-1:0] f;
    longint unsigned base;
    r = '0;
    if (!lv) return r;
    r.valid = 1;
    for (int i = 0; i < N; i++) begin
      int b = page_bits(m_mask[i]);
      if (who < 0 && b > 0) begin
        base = longint'({m_vpn[i], 13'b0});
        if ((longint'(va) >> (b + 1)) == (base >> (b + 1)) && (m_g[i] || m_asid[i] == as)) begin
          who = i; pb = b;
        end
      end
    end
    if (who < 0) begin
      r.exc = 1; r.refill = 1; r.code = w ? 2'd3 : 2'd2;
    end else begin
      odd = va[pb];
      v = odd ? m_v1[who] : m_v0[who];
      d = odd ? m_d1[who] : m_d0[who];
      f = odd ? m_p1[who] : m_p0[who];
      if (!v) begin r.exc = 1; r.code = w ? 2'd3 : 2'd2; end
      else if (w && !d) begin r.exc = 1; r.code = 2'd1; end
      else begin
        r.ok = 1; r.wr = d;
        r.pa = PW'((longint'(f) * 4096) + (longint'(va) % (64'd1 << pb)));
        r.pa = PW'((longint'(f) << 12) | (longint'(va) & ((64'd1 << pb) - 1)));
      end
    end
    if (nx && r.exc) begin r.exc = 0; r.code = 0; r.refill = 0; end
    return r;
  endfunction

  task automatic compare(input rsp_t e, input string tag);
    rsp_t a;
    a = '{rsp_valid, rsp_ok, rsp_paddr, rsp_writable, rsp_exc, rsp_exc_code, rsp_refill};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual v=%0b ok=%0b pa=%h w=%0b exc=%0b code=%0d rf=%0b expected v=%0b ok=%0b pa=%h w=%0b exc=%0b code=%0d rf=%0b",
        tag, a.valid, a.ok, a.pa, a.wr, a.exc, a.code, a.refill,
        e.valid, e.ok, e.pa, e.wr, e.exc, e.code, e.refill);
    end
  endtask

  // pending stimulus for the next cycle
  logic          q_lv = 0, q_w = 0, q_nx = 0, q_we = 0;
  logic [VW-1:0] q_va = '0;
  logic [AW-1:0] q_as = '0;

  task automatic step(input string tag);
    rsp_t e;
    @(negedge clk);
    lk_valid = q_lv; lk_vaddr = q_va; lk_asid = q_as; lk_write = q_w; lk_noexc = q_nx;
    wr_en = q_we;
    e = model(q_lv, q_va, q_as, q_w, q_nx);
    if (q_we) begin
      m_mask[wr_idx] = wr_mask; m_vpn[wr_idx] = wr_vpn2; m_asid[wr_idx] = wr_asid;
      m_g[wr_idx] = wr_global; m_p0[wr_idx] = wr_pfn0; m_v0[wr_idx] = wr_v0;
      m_d0[wr_idx] = wr_d0; m_p1[wr_idx] = wr_pfn1; m_v1[wr_idx] = wr_v1; m_d1[wr_idx] = wr_d1;
    end
    @(posedge clk); #1;
    compare(e, tag);
    q_lv = 0; q_we = 0; q_w = 0; q_nx = 0;
  endtask

  task automatic set_wr(input int idx, input logic [11:0] m, input logic [VW-1:0] va,
                        input logic [AW-1:0] as, input logic g,
                        input logic [FW-1:0] p0, input logic v0, input logic d0,
                        input logic [FW-1:0] p1, input logic v1, input logic d1);
    q_we = 1; wr_idx = IW'(idx); wr_mask = m; wr_vpn2 = va[VW-1:13]; wr_asid = as;
    wr_global = g; wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0; wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
  endtask

  task automatic set_lk(input logic [VW-1:0] va, input logic [AW-1:0] as,
                        input logic w, input logic nx);
    q_lv = 1; q_va = va; q_as = as; q_w = w; q_nx = nx;
  endtask

  task automatic expect_fixed(input logic ok, input logic [PW-1:0] pa, input logic wr,
                              input logic exc, input logic [1:0] code, input logic rf,
                              input string tag);
    rsp_t e;
    e = '{1'b1, ok, pa, wr, exc, code, rf};
    compare(e, tag);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_mask[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_g[i] = 0;
      m_p0[i] = 0; m_v0[i] = 0; m_d0[i] = 0; m_p1[i] = 0; m_v1[i] = 0; m_d1[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 compare('0, "R13 reset outputs");
    @(negedge clk) rst_n = 1;

    // R13: cleared entry 0 matches address 0 but is invalid
    set_lk(32'h0, 8'h0, 0, 0); step("R13 cleared entry");
    expect_fixed(0, '0, 0, 1, 2'd2, 0, "R13 fixed code");

    // small page pair at 0x20000, asid 3
    set_wr(5, 12'h000, 32'h0002_0000, 8'd3, 0, 24'h123, 1, 1, 24'h456, 1, 0); step("R12 load");
    set_lk(32'h0002_0ABC, 8'd3, 0, 0); step("R6 even read");
    expect_fixed(1, 36'h123ABC, 1, 0, 0, 0, "R6 even pa");
    set_lk(32'h0002_1ABC, 8'd3, 0, 0); step("R5 odd read");
    expect_fixed(1, 36'h456ABC, 0, 0, 0, 0, "R8 clean read ro");
    set_lk(32'h0002_1ABC, 8'd3, 1, 0); step("R8 clean write");
    expect_fixed(0, '0, 0, 1, 2'd1, 0, "R8 modify code");
    set_lk(32'h0002_0010, 8'd3, 1, 0); step("R6 dirty write");
    set_lk(32'h0002_0010, 8'd4, 0, 0); step("R9 asid miss load");
    expect_fixed(0, '0, 0, 1, 2'd2, 1, "R9 load refill");
    set_lk(32'h0002_0010, 8'd4, 1, 0); step("R9 asid miss store");
    expect_fixed(0, '0, 0, 1, 2'd3, 1, "R9 store refill");

    // 64 KB global pair at 0x400000
    set_wr(7, 12'h00F, 32'h0040_0000, 8'd9, 1, 24'h800, 1, 1, 24'h900, 0, 0); step("R2 load 64K");
    set_lk(32'h0040_1234, 8'd77, 0, 0); step("R4 global hit");
    expect_fixed(1, 36'h801234, 1, 0, 0, 0, "R2 64K offset");
    set_lk(32'h0041_0000, 8'd1, 0, 0); step("R7 odd invalid load");
    expect_fixed(0, '0, 0, 1, 2'd2, 0, "R7 invalid no refill");
    set_lk(32'h0041_0000, 8'd1, 1, 0); step("R7 odd invalid store");
    set_lk(32'h0042_0000, 8'd9, 0, 0); step("R4 outside pair");

    // 16 MB pair at 0x02000000
    set_wr(9, 12'hFFF, 32'h0200_0000, 8'd1, 0, 24'h0AB000, 1, 1, 24'h0CD000, 1, 1); step("R2 load 16M");
    set_lk(32'h03AB_CDEF, 8'd1, 1, 0); step("R5 16M odd");
    expect_fixed(1, 36'hCDABCDEF, 1, 0, 0, 0, "R2 16M pa");

    // illegal mask never matches
    set_wr(11, 12'h005, 32'h0800_0000, 8'd0, 1, 24'h1, 1, 1, 24'h2, 1, 1); step("R3 load bad");
    set_lk(32'h0800_0100, 8'd0, 0, 0); step("R3 illegal mask");
    expect_fixed(0, '0, 0, 1, 2'd2, 1, "R3 treated as miss");

    // priority: entry 2 overlaps entry 5
    set_wr(2, 12'h000, 32'h0002_0000, 8'd3, 0, 24'h777, 1, 1, 24'h778, 1, 1); step("R11 load");
    set_lk(32'h0002_0ABC, 8'd3, 0, 0); step("R11 lowest wins");
    expect_fixed(1, 36'h777ABC, 1, 0, 0, 0, "R11 pa");

    // quiet lookups
    set_lk(32'h0700_0000, 8'd3, 1, 1); step("R10 quiet miss");
    expect_fixed(0, '0, 0, 0, 0, 0, "R10 silent");
    set_lk(32'h0041_0000, 8'd1, 0, 1); step("R10 quiet invalid");

    // write and lookup in the same cycle
    set_wr(20, 12'h000, 32'h0010_0000, 8'd6, 0, 24'h321, 1, 1, 24'h0, 0, 0);
    set_lk(32'h0010_0040, 8'd6, 0, 0); step("R12 same cycle old");
    expect_fixed(0, '0, 0, 1, 2'd2, 1, "R12 still miss");
    set_lk(32'h0010_0040, 8'd6, 0, 0); step("R12 next cycle new");
    expect_fixed(1, 36'h321040, 1, 0, 0, 0, "R12 hit");

    step("R1 idle");
    step("R1 idle again");

    // random mix, entries 24..47
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 4) == 0) begin
        logic [11:0] mk;
        case ($urandom % 9)
          0, 1, 2: mk = 12'h000; 3: mk = 12'h003; 4: mk = 12'h00F;
          5: mk = 12'h03F; 6: mk = 12'hFFF; 7: mk = 12'h00C; default: mk = 12'h0FF;
        endcase
        set_wr(24 + int'($urandom % 24), mk, ($urandom & 32'h0007_E000), 8'($urandom % 4),
               1'($urandom % 5 == 0), FW'($urandom), 1'($urandom), 1'($urandom),
               FW'($urandom), 1'($urandom), 1'($urandom));
      end
      if (($urandom % 4) != 0)
        set_lk($urandom & 32'h0007_FFFF, 8'($urandom % 4), 1'($urandom), 1'($urandom % 6 == 0));
      step("R4 R5 R6 R7 R8 R9 R11 random");
    end

    finish_run();
  end

endmodule